// File: doc/BRIEF.md
# Atomic Coherence Bus Arbiter with Memory Responder

This block is the shared, atomic request bus for a small group of coherent cache nodes (4, 8 or 16). Each node posts a read-shared (GETS) or read-for-ownership (GETM) request for an address. Every post goes into an arbitration queue, and the bus grants one transaction at a time. A granted request holds the bus until a DATA response for it appears. Within the queue, requests keep their order of arrival. Requests posted in the same cycle are ordered by node index.

A built-in memory responder answers every granted request with DATA after a fixed latency. If a cache drives DATA first, the memory answer is cancelled. Every DATA beat names the requesting node and carries a flag that tells whether a cache or memory supplied it, so cache-to-cache transfers can be counted. A node may have only one request outstanding. A second post from a node that is already waiting or owning the bus is flagged and dropped.

The node count must be a power of two. The memory latency defaults to 100 cycles.

Top module: `coh_bus_arbiter`

## Requirements
- R1: After reset, busBusy, busValid, dataValid and dupError are all low.
- R2: A request with reqValid high in cycle c, posted to an idle bus with an empty queue, appears with busValid high in cycle c+2. busNode, busGetm (1 = GETM, 0 = GETS) and busAddr carry the posted values in that cycle.
- R3: After a grant, no further busValid occurs until the DATA cycle of that transaction has passed. busValid and dataValid are never high in the same cycle.
- R4: If no cache drives DATA, dataValid is high exactly MEM_LATENCY (100) cycles after the busValid cycle. In that cycle dataFromCache is 0 and dataNode equals the granted node.
- R5: cacheData high in a cycle while busBusy is high makes dataValid high in the next cycle with dataFromCache = 1. No memory DATA follows for that transaction.
- R6: Requests posted in different cycles are granted in the order they were posted.
- R7: Requests posted in the same cycle are granted lowest node index first.
- R8: When the queue is not empty, the queue head is granted with busValid in the cycle right after the dataValid cycle.
- R9: A post from a node whose earlier request has not yet received DATA raises dupError in the next cycle. The post is dropped and is never granted.
- R10: cacheData while the bus is idle has no effect: no dataValid follows.
- R11: If cacheData arrives in the last cycle before the memory timer expires, the cache is credited: dataFromCache = 1 in the single DATA cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_NODES | One-cycle post strobe per node |
| reqGetm | input | NUM_NODES | Per-node request type, 1 = GETM, 0 = GETS |
| reqAddr | input | NUM_NODES*ADDR_W | Per-node request address, node i at bits [i*ADDR_W +: ADDR_W] |
| cacheData | input | 1 | A cache drives DATA for the current transaction |
| busValid | output | 1 | Granted request is on the bus this cycle |
| busGetm | output | 1 | Type of the granted request |
| busNode | output | NODE_W | Node owning the bus |
| busAddr | output | ADDR_W | Address of the granted request |
| busBusy | output | 1 | Transaction in progress, from grant to the cycle before DATA |
| dataValid | output | 1 | DATA beat on the bus |
| dataNode | output | NODE_W | Requester the DATA belongs to |
| dataFromCache | output | 1 | 1 when a cache supplied the DATA, 0 when memory did |
| dupError | output | 1 | Pulse: a post arrived from a node already outstanding |

## Verification
The bench targets order corners. It posts three nodes out of index order in one cycle and a lower-indexed node one cycle later. A design that sorted by index alone would grant node 0 first, and one that ignored ties would mis-order the first three. It measures the exact memory latency and drives a cache DATA in the very cycle before the timer expires. An off-by-one timer would either miss that window or credit memory. It also checks that no second memory DATA follows a cancelled one. Duplicate posts, and cache DATA on an idle bus, are checked for what they must not cause: an extra grant, or a stray DATA beat.

// File: rtl/cba_pkg.sv
package cba_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_ACTIVE = 2'd1,
    BUS_DATA   = 2'd2
  } busState_e;

  typedef struct packed {
    logic grant;
    logic endByCache;
    logic endByMem;
  } busStrobe_t;

endpackage

// File: rtl/cba_ctrl.sv
module cba_ctrl
  import cba_pkg::*;
#(
  parameter int NUM_NODES = 8,
  localparam int NODE_W = $clog2(NUM_NODES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_NODES-1:0] reqValid,
  input  logic                 cacheData,
  input  logic                 queueEmpty,
  input  logic                 timerZero,
  input  logic [NODE_W-1:0]    ownerNode,
  output busStrobe_t           strobe,
  output logic [NUM_NODES-1:0] accept,
  output logic [NUM_NODES-1:0] pending,
  output busState_e            state,
  output logic                 dupError
);

  logic                 finish;
  logic [NUM_NODES-1:0] clrMask;

  always_comb begin
    accept            = reqValid & ~pending;
    strobe.grant      = (state != BUS_ACTIVE) && !queueEmpty;
    strobe.endByCache = (state == BUS_ACTIVE) && cacheData;
    strobe.endByMem   = (state == BUS_ACTIVE) && !cacheData && timerZero;
    finish            = strobe.endByCache || strobe.endByMem;
    clrMask           = finish ? (NUM_NODES'(1) << ownerNode) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= BUS_IDLE;
      pending  <= '0;
      dupError <= 1'b0;
    end else begin
      if (strobe.grant)           state <= BUS_ACTIVE;
      else if (finish)            state <= BUS_DATA;
      else if (state == BUS_DATA) state <= BUS_IDLE;
      pending  <= (pending | accept) & ~clrMask;
      dupError <= |(reqValid & pending);
    end
  end

  // R3: a grant is never followed by another grant on the next edge
  assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BUS_ACTIVE && !finish) |=> (state == BUS_ACTIVE || state == BUS_DATA));

endmodule

// File: rtl/cba_dpath.sv
module cba_dpath
  import cba_pkg::*;
#(
  parameter int NUM_NODES   = 8,
  parameter int ADDR_W      = 32,
  parameter int MEM_LATENCY = 100,
  localparam int NODE_W = $clog2(NUM_NODES),
  localparam int PTR_W  = $clog2(NUM_NODES),
  localparam int CNT_W  = $clog2(NUM_NODES + 1),
  localparam int TMR_W  = $clog2(MEM_LATENCY + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  busStrobe_t                  strobe,
  input  logic [NUM_NODES-1:0]        accept,
  input  logic [NUM_NODES-1:0]        reqGetm,
  input  logic [NUM_NODES*ADDR_W-1:0] reqAddr,
  output logic                        queueEmpty,
  output logic [CNT_W-1:0]            queueCount,
  output logic                        timerZero,
  output logic                        busValid,
  output logic                        busGetm,
  output logic [NODE_W-1:0]           busNode,
  output logic [ADDR_W-1:0]           busAddr,
  output logic                        dataFromCache
);

  logic [ADDR_W-1:0] slotAddr [NUM_NODES];
  logic              slotGetm [NUM_NODES];
  logic [NODE_W-1:0] fifoNode [NUM_NODES];
  logic [PTR_W-1:0]  headPtr, tailPtr;
  logic [PTR_W-1:0]  wrIdx [NUM_NODES];
  logic [CNT_W-1:0]  numAcc;
  logic [TMR_W-1:0]  timer;
  logic [NODE_W-1:0] headNode;

  // slot positions for same-cycle arrivals: lower index goes first
  always_comb begin
    logic [CNT_W-1:0] run;
    run = '0;
    for (int i = 0; i < NUM_NODES; i++) begin
      wrIdx[i] = tailPtr + run[PTR_W-1:0];
      run      = run + CNT_W'(accept[i]);
    end
    numAcc = run;
  end

  assign headNode   = fifoNode[headPtr];
  assign queueEmpty = (queueCount == '0);
  assign timerZero  = (timer == '0);

  generate
    for (genvar g = 0; g < NUM_NODES; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (accept[g]) begin
          slotAddr[g] <= reqAddr[g*ADDR_W +: ADDR_W];
          slotGetm[g] <= reqGetm[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_NODES; i++)
      if (accept[i]) fifoNode[wrIdx[i]] <= NODE_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr       <= '0;
      tailPtr       <= '0;
      queueCount    <= '0;
      timer         <= '0;
      busValid      <= 1'b0;
      busGetm       <= 1'b0;
      busNode       <= '0;
      busAddr       <= '0;
      dataFromCache <= 1'b0;
    end else begin
      tailPtr    <= tailPtr + numAcc[PTR_W-1:0];
      headPtr    <= headPtr + PTR_W'(strobe.grant);
      queueCount <= queueCount + numAcc - CNT_W'(strobe.grant);
      busValid   <= strobe.grant;
      if (strobe.grant) begin
        busNode <= headNode;
        busAddr <= slotAddr[headNode];
        busGetm <= slotGetm[headNode];
        timer   <= TMR_W'(MEM_LATENCY - 1);
      end else if (timer != '0) begin
        timer <= timer - 1'b1;
      end
      if (strobe.endByCache || strobe.endByMem)
        dataFromCache <= strobe.endByCache;
    end
  end

  // R9: one slot per node means the queue can never exceed the node count
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(queueCount) <= NUM_NODES);

endmodule

// File: rtl/coh_bus_arbiter.sv
module coh_bus_arbiter
  import cba_pkg::*;
#(
  parameter int NUM_NODES   = 8,
  parameter int ADDR_W      = 32,
  parameter int MEM_LATENCY = 100,
  localparam int NODE_W = $clog2(NUM_NODES),
  localparam int CNT_W  = $clog2(NUM_NODES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_NODES-1:0]        reqValid,
  input  logic [NUM_NODES-1:0]        reqGetm,
  input  logic [NUM_NODES*ADDR_W-1:0] reqAddr,
  input  logic                        cacheData,
  output logic                        busValid,
  output logic                        busGetm,
  output logic [NODE_W-1:0]           busNode,
  output logic [ADDR_W-1:0]           busAddr,
  output logic                        busBusy,
  output logic                        dataValid,
  output logic [NODE_W-1:0]           dataNode,
  output logic                        dataFromCache,
  output logic                        dupError
);

  busStrobe_t           strobe;
  logic [NUM_NODES-1:0] accept;
  logic [NUM_NODES-1:0] pending;
  busState_e            state;
  logic                 queueEmpty;
  logic                 timerZero;
  logic [CNT_W-1:0]     queueCount;

  cba_ctrl #(.NUM_NODES(NUM_NODES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .cacheData (cacheData),
    .queueEmpty(queueEmpty),
    .timerZero (timerZero),
    .ownerNode (busNode),
    .strobe    (strobe),
    .accept    (accept),
    .pending   (pending),
    .state     (state),
    .dupError  (dupError)
  );

  cba_dpath #(
    .NUM_NODES  (NUM_NODES),
    .ADDR_W     (ADDR_W),
    .MEM_LATENCY(MEM_LATENCY)
  ) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .accept       (accept),
    .reqGetm      (reqGetm),
    .reqAddr      (reqAddr),
    .queueEmpty   (queueEmpty),
    .queueCount   (queueCount),
    .timerZero    (timerZero),
    .busValid     (busValid),
    .busGetm      (busGetm),
    .busNode      (busNode),
    .busAddr      (busAddr),
    .dataFromCache(dataFromCache)
  );

  assign busBusy   = (state == BUS_ACTIVE);
  assign dataValid = (state == BUS_DATA);
  assign dataNode  = busNode;

  // checker-only counter: cycles elapsed since the last busValid
  logic [15:0] sinceGrant;
  always_ff @(posedge clk) begin
    if (!rst_n)                    sinceGrant <= '0;
    else if (busValid)             sinceGrant <= 16'd1;
    else if (sinceGrant != 16'hFFFF) sinceGrant <= sinceGrant + 16'd1;
  end

  // R4: memory DATA lands exactly MEM_LATENCY cycles after the grant
  assert_mem_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dataValid && !dataFromCache) |-> (sinceGrant == 16'(MEM_LATENCY)));

  // R5: cache DATA during a tenure ends it next cycle, credited to the cache
  assert_cache_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busBusy && cacheData) |=> (dataValid && dataFromCache));

  // R3: grant and DATA never share a cycle; no two grants in a row
  assert_grant_data_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busValid |-> !dataValid);
  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busValid |=> !busValid);

  // R10: DATA only ever closes a tenure that was open
  assert_data_needs_tenure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> $past(busBusy));

  // R9: outstanding nodes equal queued entries plus the current owner
  assert_pending_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pending) == int'(queueCount) + (busBusy ? 1 : 0));

endmodule

// File: tb/coh_bus_arbiter_bench.sv
`timescale 1ns/1ps
module coh_bus_arbiter_bench;

  localparam int N   = 8;
  localparam int AW  = 32;
  localparam int LAT = 100;
  localparam int NW  = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    reqValid = '0;
  logic [N-1:0]    reqGetm = '0;
  logic [N*AW-1:0] reqAddr = '0;
  logic            cacheData;
  logic            busValid, busGetm, busBusy, dataValid, dataFromCache, dupError;
  logic [NW-1:0]   busNode, dataNode;
  logic [AW-1:0]   busAddr;

  logic manualPulse = 1'b0;
  logic autoPulse   = 1'b0;
  logic autoOn      = 1'b0;
  int   autoCnt     = 0;
  assign cacheData = manualPulse | autoPulse;

  coh_bus_arbiter #(.NUM_NODES(N), .ADDR_W(AW), .MEM_LATENCY(LAT)) u_coh_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqGetm(reqGetm), .reqAddr(reqAddr),
    .cacheData(cacheData), .busValid(busValid), .busGetm(busGetm), .busNode(busNode),
    .busAddr(busAddr), .busBusy(busBusy), .dataValid(dataValid), .dataNode(dataNode),
    .dataFromCache(dataFromCache), .dupError(dupError)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // event logs, filled at the falling edge
  int gN, dN, eN;
  int gCyc [32]; int gNode [32]; int gGetm [32]; logic [AW-1:0] gAddr [32];
  int dCyc [32]; int dNodeL [32]; int dCache [32];
  int eCyc [32];

  always @(negedge clk) begin
    if (busValid && gN < 32) begin
      gCyc[gN] = cyc; gNode[gN] = int'(busNode); gGetm[gN] = int'(busGetm);
      gAddr[gN] = busAddr; gN++;
    end
    if (dataValid && dN < 32) begin
      dCyc[dN] = cyc; dNodeL[dN] = int'(dataNode); dCache[dN] = int'(dataFromCache); dN++;
    end
    if (dupError && eN < 32) begin
      eCyc[eN] = cyc; eN++;
    end
    if (autoOn && busBusy) begin
      autoCnt++;
      autoPulse = (autoCnt == 3);
    end else begin
      autoCnt = 0;
      autoPulse = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearLogs();
    gN = 0; dN = 0; eN = 0;
  endtask

  task automatic setReq(input int n, input bit getm, input logic [AW-1:0] a);
    reqValid[n] = 1'b1;
    reqGetm[n]  = getm;
    reqAddr[n*AW +: AW] = a;
  endtask

  task automatic endPost();
    @(negedge clk);
    reqValid = '0;
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulseCache();
    manualPulse = 1'b1;
    @(negedge clk);
    manualPulse = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(busBusy == 0, "R1", "busBusy after reset", busBusy, 0);
    chk(busValid == 0, "R1", "busValid after reset", busValid, 0);
    chk(dataValid == 0, "R1", "dataValid after reset", dataValid, 0);
    chk(dupError == 0, "R1", "dupError after reset", dupError, 0);
  endtask

  task automatic testMemoryPath();
    int c;
    clearLogs();
    @(negedge clk);
    c = cyc;
    setReq(2, 1'b0, 32'h1000_0040);
    endPost();
    waitTo(c + 5);
    setReq(0, 1'b1, 32'h2000_0080);
    endPost();
    waitTo(c + 2 + 2*LAT + 8);
    chk(gN == 2, "R2", "grant count", gN, 2);
    chk(gCyc[0] == c + 2, "R2", "grant cycle", gCyc[0], c + 2);
    chk(gNode[0] == 2, "R2", "grant node", gNode[0], 2);
    chk(gGetm[0] == 0, "R2", "grant type GETS", gGetm[0], 0);
    chk(gAddr[0] == 32'h1000_0040, "R2", "grant address", gAddr[0], 32'h1000_0040);
    chk(dCyc[0] == c + 2 + LAT, "R4", "memory DATA cycle", dCyc[0], c + 2 + LAT);
    chk(dCache[0] == 0, "R4", "memory credited", dCache[0], 0);
    chk(dNodeL[0] == 2, "R4", "DATA node", dNodeL[0], 2);
    chk(gCyc[1] == c + 3 + LAT, "R3", "second grant waits for DATA", gCyc[1], c + 3 + LAT);
    chk(gGetm[1] == 1, "R2", "second grant type GETM", gGetm[1], 1);
  endtask

  task automatic testCachePreempt();
    int c;
    clearLogs();
    @(negedge clk);
    c = cyc;
    setReq(5, 1'b1, 32'h0000_ABC0);
    endPost();
    waitTo(c + 12);
    pulseCache();
    waitTo(c + 12 + LAT + 20);
    chk(dN == 1, "R5", "exactly one DATA beat", dN, 1);
    chk(dCyc[0] == c + 13, "R5", "cache DATA cycle", dCyc[0], c + 13);
    chk(dCache[0] == 1, "R5", "cache credited", dCache[0], 1);
    chk(dNodeL[0] == 5, "R5", "DATA node", dNodeL[0], 5);
  endtask

  task automatic testTie();
    int c, g;
    clearLogs();
    @(negedge clk);
    c = cyc;
    g = c + 2;
    setReq(1, 1'b0, 32'h0000_0100);
    endPost();
    waitTo(g + LAT - 1);
    pulseCache();
    waitTo(g + LAT + 15);
    chk(dN == 1, "R11", "single DATA at tie", dN, 1);
    chk(dCyc[0] == g + LAT, "R11", "tie DATA cycle", dCyc[0], g + LAT);
    chk(dCache[0] == 1, "R11", "tie credited to cache", dCache[0], 1);
  endtask

  task automatic testSameCycle();
    int c;
    int expOrder [4] = '{1, 3, 6, 0};
    clearLogs();
    autoOn = 1'b1;
    @(negedge clk);
    c = cyc;
    setReq(6, 1'b0, 32'h60); setReq(1, 1'b0, 32'h10); setReq(3, 1'b1, 32'h30);
    @(negedge clk);
    reqValid = '0;
    setReq(0, 1'b0, 32'h00);
    endPost();
    waitTo(c + 40);
    autoOn = 1'b0;
    chk(gN == 4, "R7", "grant count", gN, 4);
    for (int k = 0; k < 3; k++)
      chk(gNode[k] == expOrder[k], "R7", "same-cycle order", gNode[k], expOrder[k]);
    chk(gNode[3] == 0, "R6", "later arrival after earlier ones", gNode[3], 0);
    for (int k = 1; k < 4; k++)
      chk(gCyc[k] == dCyc[k-1] + 1, "R8", "grant right after DATA", gCyc[k], dCyc[k-1] + 1);
  endtask

  task automatic testArrival();
    int c;
    clearLogs();
    autoOn = 1'b1;
    @(negedge clk);
    c = cyc;
    setReq(4, 1'b0, 32'h40);
    endPost();
    waitTo(c + 3);
    setReq(7, 1'b0, 32'h70);
    endPost();
    setReq(0, 1'b0, 32'h08);
    endPost();
    waitTo(c + 40);
    autoOn = 1'b0;
    chk(gN == 3, "R6", "grant count", gN, 3);
    chk(gNode[1] == 7, "R6", "earlier post from node 7 first", gNode[1], 7);
    chk(gNode[2] == 0, "R6", "node 0 after node 7", gNode[2], 0);
  endtask

  task automatic testDuplicate();
    int c;
    clearLogs();
    @(negedge clk);
    c = cyc;
    setReq(3, 1'b0, 32'h300);
    endPost();
    waitTo(c + 5);
    setReq(3, 1'b1, 32'h333);
    endPost();
    waitTo(c + 8);
    pulseCache();
    waitTo(c + 30);
    chk(eN == 1, "R9", "dupError pulses", eN, 1);
    chk(eCyc[0] == c + 6, "R9", "dupError cycle", eCyc[0], c + 6);
    chk(gN == 1, "R9", "duplicate never granted", gN, 1);
    chk(dN == 1, "R9", "one DATA only", dN, 1);
  endtask

  task automatic testIdleCache();
    clearLogs();
    @(negedge clk);
    pulseCache();
    repeat (6) @(negedge clk);
    chk(dN == 0, "R10", "no DATA from idle cacheData", dN, 0);
    chk(gN == 0, "R10", "no grant from idle cacheData", gN, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clearLogs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testMemoryPath();
    testCachePreempt();
    testTie();
    testSameCycle();
    testArrival();
    testDuplicate();
    testIdleCache();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule